// File: doc/BRIEF.md
# Analog Input Conversion Sequencer

This block is the control core of a four-channel, 16-bit analog input module. A host reaches it over a simple byte-wide register bus. The host loads a small channel list, in which each entry holds a channel number, a gain code, a multiplexer enable and an on-board-only flag. It also loads a settling count and picks one of four time bases. A read of the start address launches a conversion. The sequencer then lets the selected gain stage settle for the programmed number of time-base ticks, asks an external converter for a sample, and latches the 16-bit two's-complement result when the converter answers.

The gain and multiplexer selects are driven from the channel-list entry that the scan pointer addresses. After each conversion the pointer steps on, and it wraps to entry 0 after the programmed last-channel index. A status byte shows a busy flag and three sticky error flags: a start while busy, a result overwritten before it was read, and a start with a zero settling count. Reading the status byte returns these flags and then clears them.

Top module: `aiseq_top`

## Requirements
- R1: A read of address 0x00 returns 0x77.
- R2: After reset, conv_req is low, the status byte (0x12) reads 0x00 and the scan pointer (0x14) reads 0.
- R3: A read of 0x04 starts a conversion only when enable (bit 2 of 0x10) is set, and status bit 7 (busy) is then high. With enable clear, the read has no effect and status stays 0x00.
- R4: conv_req rises exactly N*D+1 clock edges after the start edge. N is the count in 0x15. D = 4^T, where T is option bits 2:1 at 0x11.
- R5: conv_req stays high until conv_done. On the edge that samples conv_done high, the result is latched, conv_req falls and busy clears.
- R6: The latched result reads back as its low byte at 0x02 and its high byte at 0x03.
- R7: A start while busy sets status bit 2 and does not change the running conversion's timing.
- R8: Latching a result while the previous one has not had its high byte (0x03) read sets status bit 1.
- R9: A start with N = 0 sets status bit 0, and conv_req rises one edge later.
- R10: A read of 0x12 returns the error bits and then clears bits 2:0, unless an error event occurs on the same edge.
- R11: Channel-list entries sit at 0x80+i. In each entry, bits 1:0 are the channel, bit 2 is the mux enable, bits 4:3 are the gain and bit 5 is on-board-only. The gain_sel, mux_sel and mux_en outputs follow the entry at the scan pointer. The pointer advances after each conversion and wraps to 0 after the index held in 0x13.
- R12: Any write to 0x19 sets the scan pointer to 0. Any write to 0x1B during settling restarts the countdown, so conv_req rises N*D+1 edges after that write.
- R13: The registers at 0x10, 0x11, 0x13 and 0x15 read back the value written. For 0x10, only bit 2 is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; data appears the cycle after |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| conv_req | output | 1 | Conversion request to the external converter |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | 16 | Converter result, two's complement |
| gain_sel | output | 2 | Gain code of the current list entry |
| mux_sel | output | 2 | Channel of the current list entry |
| mux_en | output | 1 | Multiplexer enable of the current list entry |

## Verification
The assertions take three things for granted about the inputs. First, conv_done arrives only while conv_req is high and lasts one cycle. Second, bus strobes are single-cycle. Third, a read and a write never occur together. The stimulus keeps within these limits because a converter model answers only after it sees conv_req rise, drops conv_done on the next cycle, and issues every bus access from tasks that raise one strobe for exactly one cycle. Settling windows are timed by edge counts in the bench rather than by deep past-value checks.

// File: rtl/aiseq_pkg.sv
`timescale 1ns/1ps
package aiseq_pkg;
    localparam logic [7:0] ID_VALUE   = 8'h77;
    localparam logic [7:0] A_ID       = 8'h00;
    localparam logic [7:0] A_RES_LO   = 8'h02;
    localparam logic [7:0] A_RES_HI   = 8'h03;
    localparam logic [7:0] A_START    = 8'h04;
    localparam logic [7:0] A_CFG      = 8'h10;
    localparam logic [7:0] A_OPT      = 8'h11;
    localparam logic [7:0] A_STAT     = 8'h12;
    localparam logic [7:0] A_LAST     = 8'h13;
    localparam logic [7:0] A_PTR      = 8'h14;
    localparam logic [7:0] A_SETTLE   = 8'h15;
    localparam logic [7:0] A_SCAN_RST = 8'h19;
    localparam logic [7:0] A_CNT_RST  = 8'h1B;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_CONV   = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [1:0] pad;
        logic       onboard;
        logic [1:0] gain;
        logic       mux_en;
        logic [1:0] chan;
    } chan_entry_t;

    typedef struct packed {
        logic [1:0] rsv_hi;
        logic       trig_en;
        logic       trig_inv;
        logic       rsv_mid;
        logic [1:0] tbase;
        logic       burst;
    } opt_t;

    typedef struct packed {
        logic pacer;
        logic data;
        logic settle;
    } err_t;

    // Prescale ratio for a time-base code: 1 << (code * step)
    function automatic int unsigned tb_divisor(logic [1:0] code, int unsigned step);
        return 32'd1 << (int'(code) * step);
    endfunction
endpackage

// File: rtl/aiseq_settle.sv
`timescale 1ns/1ps
module aiseq_settle #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned TB_STEP = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] init,
    input  logic [1:0]       tbase,
    output logic             expired
);
    localparam int unsigned PRE_W = 3 * TB_STEP + 1;

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] pre_top;
    logic [CNT_W-1:0] cnt;

    assign pre_top = PRE_W'(aiseq_pkg::tb_divisor(tbase, TB_STEP) - 1);
    assign expired = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre <= '0;
            cnt <= '0;
        end else if (load) begin
            pre <= '0;
            cnt <= init;
        end else if (run && !expired) begin
            if (pre == pre_top) begin
                pre <= '0;
                cnt <= cnt - 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end
endmodule

// File: rtl/aiseq_scan.sv
`timescale 1ns/1ps
module aiseq_scan
    import aiseq_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  chan_entry_t      wr_data,
    input  logic             advance,
    input  logic             clear,
    input  logic [PTR_W-1:0] last,
    input  logic [PTR_W-1:0] rd_idx,
    output chan_entry_t      rd_entry,
    output chan_entry_t      cur,
    output logic [PTR_W-1:0] ptr
);
    chan_entry_t list [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                list[g] <= '0;
            else if (wr_en && (wr_idx == PTR_W'(g)))
                list[g] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            ptr <= '0;
        else if (advance)
            ptr <= (ptr == last) ? '0 : ptr + 1'b1;
    end

    assign cur      = list[ptr];
    assign rd_entry = list[rd_idx];
endmodule

// File: rtl/aiseq_fsm.sv
`timescale 1ns/1ps
module aiseq_fsm
    import aiseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_ok,
    input  logic       expired,
    input  logic       conv_done,
    output seq_state_t state
);
    seq_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start_ok)  nxt = ST_SETTLE;
            ST_SETTLE: if (expired)   nxt = ST_CONV;
            ST_CONV:   if (conv_done) nxt = ST_IDLE;
            default:                  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/aiseq_top.sv
`timescale 1ns/1ps
module aiseq_top
    import aiseq_pkg::*;
#(
    parameter int unsigned LIST_DEPTH = 4,
    parameter int unsigned TB_STEP    = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        conv_req,
    input  logic        conv_done,
    input  logic [15:0] conv_data,
    output logic [1:0]  gain_sel,
    output logic [1:0]  mux_sel,
    output logic        mux_en
);
    localparam int unsigned PTR_W  = (LIST_DEPTH > 1) ? $clog2(LIST_DEPTH) : 1;
    localparam int unsigned CNT_W  = 8;
    localparam int unsigned DATA_W = 16;

    // host registers
    logic              enable;
    opt_t              opt;
    logic [7:0]        last_reg;
    logic [CNT_W-1:0]  settle_reg;
    logic [DATA_W-1:0] result;
    logic              unread;
    err_t              err;

    seq_state_t        state;
    logic              busy;
    logic              expired;
    chan_entry_t       cur_entry;
    chan_entry_t       rd_entry;
    logic [PTR_W-1:0]  ptr;

    // bus decode
    logic start_rd, stat_rd, hi_rd;
    logic scan_clr, cnt_rst, list_hit, list_wr;
    logic start_ok, latch, settle_load;
    logic err_pacer, err_data, err_settle;

    assign start_rd = bus_rd && (bus_addr == A_START);
    assign stat_rd  = bus_rd && (bus_addr == A_STAT);
    assign hi_rd    = bus_rd && (bus_addr == A_RES_HI);
    assign scan_clr = bus_wr && (bus_addr == A_SCAN_RST);
    assign cnt_rst  = bus_wr && (bus_addr == A_CNT_RST);
    assign list_hit = bus_addr[7] && (bus_addr[6:0] < 7'(LIST_DEPTH));
    assign list_wr  = bus_wr && list_hit;

    assign busy        = (state != ST_IDLE);
    assign start_ok    = start_rd && enable && !busy;
    assign latch       = (state == ST_CONV) && conv_done;
    assign settle_load = start_ok || (cnt_rst && state == ST_SETTLE);

    assign err_pacer   = err.pacer;
    assign err_data    = err.data;
    assign err_settle  = err.settle;

    aiseq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_ok  (start_ok),
        .expired   (expired),
        .conv_done (conv_done),
        .state     (state)
    );

    aiseq_settle #(.CNT_W(CNT_W), .TB_STEP(TB_STEP)) u_settle (
        .clk     (clk),
        .rst     (rst),
        .load    (settle_load),
        .run     (state == ST_SETTLE),
        .init    (settle_reg),
        .tbase   (opt.tbase),
        .expired (expired)
    );

    aiseq_scan #(.DEPTH(LIST_DEPTH)) u_scan (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (list_wr),
        .wr_idx   (bus_addr[PTR_W-1:0]),
        .wr_data  (chan_entry_t'(bus_wdata)),
        .advance  (latch),
        .clear    (scan_clr),
        .last     (last_reg[PTR_W-1:0]),
        .rd_idx   (bus_addr[PTR_W-1:0]),
        .rd_entry (rd_entry),
        .cur      (cur_entry),
        .ptr      (ptr)
    );

    assign conv_req = (state == ST_CONV);
    assign gain_sel = cur_entry.gain;
    assign mux_sel  = cur_entry.chan;
    assign mux_en   = cur_entry.mux_en;

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            enable     <= 1'b0;
            opt        <= '0;
            last_reg   <= '0;
            settle_reg <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                A_CFG:    enable     <= bus_wdata[2];
                A_OPT:    opt        <= opt_t'(bus_wdata);
                A_LAST:   last_reg   <= bus_wdata;
                A_SETTLE: settle_reg <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // result capture and unread tracking
    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            unread <= 1'b0;
        end else if (latch) begin
            result <= conv_data;
            unread <= 1'b1;
        end else if (hi_rd) begin
            unread <= 1'b0;
        end
    end

    // sticky error flags, cleared by a status read
    always_ff @(posedge clk) begin
        if (rst) begin
            err <= '0;
        end else begin
            err.pacer  <= (start_rd && enable && busy)          || (err.pacer  && !stat_rd);
            err.data   <= (latch && unread)                     || (err.data   && !stat_rd);
            err.settle <= (start_ok && settle_reg == '0)        || (err.settle && !stat_rd);
        end
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            unique case (bus_addr)
                A_ID:     bus_rdata <= ID_VALUE;
                A_RES_LO: bus_rdata <= result[7:0];
                A_RES_HI: bus_rdata <= result[15:8];
                A_CFG:    bus_rdata <= {5'b0, enable, 2'b0};
                A_OPT:    bus_rdata <= opt;
                A_STAT:   bus_rdata <= {busy, 4'b0, err};
                A_LAST:   bus_rdata <= last_reg;
                A_PTR:    bus_rdata <= 8'(ptr);
                A_SETTLE: bus_rdata <= settle_reg;
                default:  bus_rdata <= list_hit ? rd_entry : 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/aiseq_chk.sv
`timescale 1ns/1ps
module aiseq_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic       conv_req,
    input logic       conv_done,
    input logic       busy,
    input logic       start_rd,
    input logic       pacer_flag,
    input logic [4:0] sel_bus
);
    // R2
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!conv_req && !busy));

    // R3
    req_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
        conv_req |-> busy);

    // R5
    req_held_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_req && !conv_done) |=> conv_req);

    // R5
    done_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_req && conv_done) |=> (!conv_req && !busy));

    // R7
    pacer_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (start_rd && busy) |=> pacer_flag);

    // R11
    sel_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (!conv_req && !bus_wr) |=> $stable(sel_bus));
endmodule

bind aiseq_top aiseq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .conv_req   (conv_req),
    .conv_done  (conv_done),
    .busy       (busy),
    .start_rd   (start_rd),
    .pacer_flag (err_pacer),
    .sel_bus    ({gain_sel, mux_sel, mux_en})
);

// File: tb/tb_aiseq_top.sv
`timescale 1ns/1ps
module tb_aiseq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        conv_req;
    logic        conv_done = 1'b0;
    logic [15:0] conv_data = '0;
    logic [1:0]  gain_sel;
    logic [1:0]  mux_sel;
    logic        mux_en;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int start_cyc = 0;
    bit finished = 0;

    typedef struct {
        int          delay;
        logic [15:0] data;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    aiseq_top dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_req(conv_req),
        .conv_done(conv_done), .conv_data(conv_data), .gain_sel(gain_sel),
        .mux_sel(mux_sel), .mux_en(mux_en)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic start();
        logic [7:0] dummy;
        rd(8'h04, dummy);
        start_cyc = cyc;
    endtask

    task automatic wait_idle(output logic [7:0] st);
        st = 8'h80;
        for (int i = 0; i < 500 && st[7]; i++) rd(8'h12, st);
    endtask

    // Driver: program, push expectation, start, await, read back
    task automatic convert(int n, int tb, logic [15:0] data, bit read_hi,
                           output logic [7:0] st);
        logic [7:0] lo, hi;
        exp_t e;
        wr(8'h15, 8'(n));
        wr(8'h11, 8'(tb << 1));
        e.delay = n * (1 << (2 * tb)) + 1;
        e.data  = data;
        sb.push_back(e);
        start();
        wait_idle(st);
        chk("R5 busy cleared after done", int'(st[7]), 0);
        chk("R5 conv_req low after done", int'(conv_req), 0);
        rd(8'h02, lo);
        chk("R6 result low byte", int'(lo), int'(data[7:0]));
        if (read_hi) begin
            rd(8'h03, hi);
            chk("R6 result high byte", int'(hi), int'(data[15:8]));
        end
    endtask

    // Monitor / converter model: checks request timing, answers with data
    initial begin
        exp_t item;
        forever begin
            @(negedge clk);
            if (conv_req && !rst) begin
                if (sb.size() == 0) begin
                    chk("R3 unexpected conv_req", 1, 0);
                    item.delay = 0; item.data = '0;
                end else begin
                    item = sb.pop_front();
                    chk("R4 settle delay edges", cyc - start_cyc, item.delay);
                end
                repeat (3) @(negedge clk);
                chk("R5 conv_req held until done", int'(conv_req), 1);
                conv_data = item.data;
                conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, st;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2 reset state
        chk("R2 conv_req after reset", int'(conv_req), 0);
        rd(8'h12, v); chk("R2 status after reset", int'(v), 8'h00);
        rd(8'h14, v); chk("R2 pointer after reset", int'(v), 0);
        // R1 identification
        rd(8'h00, v); chk("R1 id byte", int'(v), 8'h77);

        // R3 start ignored while disabled
        start();
        repeat (4) @(negedge clk);
        chk("R3 no request while disabled", int'(conv_req), 0);
        rd(8'h12, v); chk("R3 status while disabled", int'(v), 8'h00);

        // R13 register readback
        wr(8'h10, 8'hFF); rd(8'h10, v); chk("R13 config readback", int'(v), 8'h04);
        wr(8'h11, 8'h32); rd(8'h11, v); chk("R13 option readback", int'(v), 8'h32);
        wr(8'h15, 8'h5A); rd(8'h15, v); chk("R13 settle readback", int'(v), 8'h5A);
        wr(8'h13, 8'h01); rd(8'h13, v); chk("R13 last readback", int'(v), 8'h01);

        // R11 channel list: entry0 chan1 mux1 gain1; entry1 chan2 mux0 gain2 onboard
        wr(8'h80, 8'h0D);
        wr(8'h81, 8'h32);
        rd(8'h81, v); chk("R11 entry readback", int'(v), 8'h32);
        chk("R11 gain entry0", int'(gain_sel), 1);
        chk("R11 chan entry0", int'(mux_sel), 1);
        chk("R11 muxen entry0", int'(mux_en), 1);

        // R3 busy visible during settling
        wr(8'h15, 8'd3); wr(8'h11, 8'h02);
        begin exp_t e; e.delay = 13; e.data = 16'h8123; sb.push_back(e); end
        start();
        rd(8'h12, v); chk("R3 busy after start", int'(v), 8'h80);
        wait_idle(st);
        rd(8'h02, v); chk("R6 low byte 0x8123", int'(v), 8'h23);
        rd(8'h03, v); chk("R6 high byte 0x8123", int'(v), 8'h81);
        chk("R11 gain entry1", int'(gain_sel), 2);
        chk("R11 chan entry1", int'(mux_sel), 2);
        chk("R11 muxen entry1", int'(mux_en), 0);
        rd(8'h14, v); chk("R11 pointer advanced", int'(v), 1);

        // R4 other time bases; pointer wraps after last=1
        convert(5, 0, 16'h7FFE, 1, st);
        rd(8'h14, v); chk("R11 pointer wrapped", int'(v), 0);
        convert(2, 2, 16'hFFFF, 1, st);
        convert(1, 3, 16'h0001, 1, st);
        chk("R8 no data error when read", int'(st[1]), 0);

        // R7 start while busy; R10 status clear on read
        wr(8'h15, 8'd4); wr(8'h11, 8'h02);
        begin exp_t e; e.delay = 17; e.data = 16'h1234; sb.push_back(e); end
        start();
        begin logic [7:0] d2; rd(8'h04, d2); end
        rd(8'h12, v); chk("R7 pacer error flagged", int'(v), 8'h84);
        rd(8'h12, v); chk("R10 error cleared by status read", int'(v), 8'h80);
        wait_idle(st);
        rd(8'h03, v); chk("R7 result intact", int'(v), 8'h12);

        // R9 zero settling count
        wr(8'h15, 8'd0);
        begin exp_t e; e.delay = 1; e.data = 16'hA55A; sb.push_back(e); end
        start();
        rd(8'h12, v); chk("R9 settle error flagged", int'(v), 8'h81);
        wait_idle(st);
        rd(8'h03, v); chk("R9 result high", int'(v), 8'hA5);

        // R8 data error: skip high byte read, then convert again
        convert(2, 0, 16'h4321, 0, st);
        convert(2, 0, 16'h5678, 1, st);
        chk("R8 data error flagged", int'(st), 8'h02);
        convert(2, 0, 16'h0F0F, 1, st);
        chk("R8 no data error after read", int'(st), 8'h00);

        // R12 scanner reset
        rd(8'h14, v); chk("R12 pointer before reset", int'(v), 1);
        wr(8'h19, 8'h00);
        rd(8'h14, v); chk("R12 pointer after scanner reset", int'(v), 0);
        chk("R12 outputs follow entry0", int'(gain_sel), 1);

        // R12 settle counter restart
        wr(8'h15, 8'd3); wr(8'h11, 8'h02);
        begin exp_t e; e.delay = 13; e.data = 16'hBEEF; sb.push_back(e); end
        start();
        repeat (5) @(negedge clk);
        wr(8'h1B, 8'h00);
        start_cyc = cyc;
        wait_idle(st);
        rd(8'h03, v); chk("R12 result after restart", int'(v), 8'hBE);

        repeat (5) @(negedge clk);
        chk("R4 scoreboard drained", sb.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule